// File: doc/BRIEF.md
# Masked Polarity Sum-of-Products Macrocell

This block is one cell of a sequencing logic array. It produces a single registered
sequencing output from 21 monitored signals: the outputs of the eight sibling cells,
seven supply-fault flags, four general-purpose inputs, and the watchdog's pulsed and
latched outputs. Nine such cells sit side by side, and each one feeds its registered
output back to the other eight.

Two product terms, A and B, each see all 21 inputs. Each term has its own invert bit
and its own ignore bit for every input. A term is the AND of the inputs it does not
ignore, each taken after its invert bit is applied. The cell output is the OR of both
terms, gated by an enable bit, and is captured on the system clock. The register
breaks any combinational loop through the sibling feedback. Every configuration field
arrives as a parallel vector.

Top module: `sop_macrocell`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `cell_q` is 0. All configuration vectors reset to 0 outside the block; the cell itself holds no configuration.
- R2: Bit positions in every 21-bit configuration vector are fixed: bits 7..0 are the sibling inputs, bits 14..8 the fault flags, bits 18..15 the general-purpose inputs, bit 19 the pulsed watchdog output and bit 20 the latched watchdog output. When an invert bit is 1, the matching input takes part in its term inverted.
- R3: When an ignore bit is 1, the matching input has no effect on its term.
- R4: A term whose 21 ignore bits are all 1 evaluates to 0.
- R5: Terms A and B use separate invert and ignore vectors. Settings for one term do not change the other.
- R6: With enable high, the output is 1 when either term is 1, and 0 when both are 0.
- R7: With enable low, the output is 0 whatever the terms evaluate to.
- R8: The output changes only at a clock edge, one cycle after the inputs that produce it. A change in inputs between edges does not show on the output before the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sib_in | input | 8 | Registered outputs of sibling cells |
| flt_in | input | 7 | Supply-fault flags |
| gp_in | input | 4 | General-purpose logic inputs |
| wd_pulse | input | 1 | Watchdog pulsed output |
| wd_latch | input | 1 | Watchdog latched output |
| inv_a | input | 21 | Invert bits for term A |
| ign_a | input | 21 | Ignore bits for term A |
| inv_b | input | 21 | Invert bits for term B |
| ign_b | input | 21 | Ignore bits for term B |
| cell_en | input | 1 | Output enable |
| cell_q | output | 1 | Registered sequencing output |

## Verification
The assertions assume that the enable and both ignore vectors are driven to known
values on every edge after reset. The stability check also assumes that inputs change
only between edges, so that one sampled set of inputs defines the next output. The bench
changes every input and configuration field only at falling edges, never while reset is
being released. It also holds the configuration steady for the cycle after reset, so
that the first output after reset reflects a fully defined input set.

// File: rtl/sop_macrocell.sv
module sop_macrocell #(
  parameter int SIB_W = 8,
  parameter int FLT_W = 7,
  parameter int GP_W  = 4,
  localparam int IN_W = SIB_W + FLT_W + GP_W + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SIB_W-1:0] sib_in,
  input  logic [FLT_W-1:0] flt_in,
  input  logic [GP_W-1:0]  gp_in,
  input  logic            wd_pulse,
  input  logic            wd_latch,
  input  logic [IN_W-1:0] inv_a,
  input  logic [IN_W-1:0] ign_a,
  input  logic [IN_W-1:0] inv_b,
  input  logic [IN_W-1:0] ign_b,
  input  logic            cell_en,
  output logic            cell_q
);

  logic [IN_W-1:0] vin;
  logic [IN_W-1:0] lit_a, lit_b;
  logic            term_a, term_b;

  assign vin = {wd_latch, wd_pulse, gp_in, flt_in, sib_in};

  for (genvar i = 0; i < IN_W; i++) begin : g_lit
    assign lit_a[i] = (vin[i] ^ inv_a[i]) | ign_a[i];
    assign lit_b[i] = (vin[i] ^ inv_b[i]) | ign_b[i];
  end

  assign term_a = (~&ign_a) & (&lit_a);
  assign term_b = (~&ign_b) & (&lit_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cell_q <= 1'b0;
    else        cell_q <= cell_en & (term_a | term_b);
  end

endmodule

// File: rtl/sop_macrocell_chk.sv
module sop_macrocell_chk #(
  parameter int IN_W = 21
) (
  input logic            clk,
  input logic            rst_n,
  input logic [7:0]      sib_in,
  input logic [6:0]      flt_in,
  input logic [3:0]      gp_in,
  input logic            wd_pulse,
  input logic            wd_latch,
  input logic [IN_W-1:0] inv_a,
  input logic [IN_W-1:0] ign_a,
  input logic [IN_W-1:0] inv_b,
  input logic [IN_W-1:0] ign_b,
  input logic            cell_en,
  input logic            cell_q
);

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R7
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cell_en |=> !cell_q);

  // R7
  high_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && cell_q) |-> $past(cell_en));

  // R4
  all_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((&ign_a) && (&ign_b)) |=> !cell_q);

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $stable(sib_in) && $stable(flt_in) && $stable(gp_in) &&
     $stable(wd_pulse) && $stable(wd_latch) && $stable(inv_a) && $stable(ign_a) &&
     $stable(inv_b) && $stable(ign_b) && $stable(cell_en)) |=> $stable(cell_q));

endmodule

bind sop_macrocell sop_macrocell_chk #(.IN_W(21)) u_chk (
  .clk(clk), .rst_n(rst_n), .sib_in(sib_in), .flt_in(flt_in), .gp_in(gp_in),
  .wd_pulse(wd_pulse), .wd_latch(wd_latch), .inv_a(inv_a), .ign_a(ign_a),
  .inv_b(inv_b), .ign_b(ign_b), .cell_en(cell_en), .cell_q(cell_q)
);

// File: tb/sim_sop_macrocell.sv
module sim_sop_macrocell;
  localparam int CLK_PERIOD = 10;
  localparam int N = 21;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] vin = '0;
  logic [N-1:0] inv_a = '0, ign_a = '0, inv_b = '0, ign_b = '0;
  logic cell_en = 1'b0;
  logic cell_q;

  int nvec = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sop_macrocell u0 (
    .clk(clk), .rst_n(rst_n),
    .sib_in(vin[7:0]), .flt_in(vin[14:8]), .gp_in(vin[18:15]),
    .wd_pulse(vin[19]), .wd_latch(vin[20]),
    .inv_a(inv_a), .ign_a(ign_a), .inv_b(inv_b), .ign_b(ign_b),
    .cell_en(cell_en), .cell_q(cell_q)
  );

  function automatic bit term(input logic [N-1:0] v, input logic [N-1:0] iv,
                              input logic [N-1:0] ig);
    bit r;
    int used;
    r = 1'b1;
    used = 0;
    for (int i = 0; i < N; i++) begin
      if (!ig[i]) begin
        used++;
        if ((v[i] ^ iv[i]) == 1'b0) r = 1'b0;
      end
    end
    return (used > 0) && r;
  endfunction

  function automatic bit expect_q();
    return cell_en && (term(vin, inv_a, ign_a) || term(vin, inv_b, ign_b));
  endfunction

  task automatic chk(input string req, input bit act, input bit exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: cell_q=%0b expected %0b", req, act, exp);
    end
  endtask

  task automatic step(input string req);
    bit e;
    e = expect_q();
    @(posedge clk);
    @(negedge clk);
    chk(req, cell_q, e);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nfail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    ign_a = '1; ign_b = '1; cell_en = 1'b1; vin = '1;
    repeat (3) @(negedge clk);
    chk("R1", cell_q, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", cell_q, 1'b0);

    // R2: invert bit per position, including watchdog bits 19 and 20
    for (int k = 0; k < N; k++) begin
      ign_a = ~(N'(1) << k); inv_a = N'(1) << k; ign_b = '1; cell_en = 1'b1;
      vin = '0; step("R2");
      vin = N'(1) << k; step("R2");
      inv_a = '0; step("R2");
    end

    // R3: ignored input cannot pull the term low
    for (int k = 0; k < N; k++) begin
      inv_a = '0; ign_b = '1; vin = ~(N'(1) << k);
      ign_a = N'(1) << k; step("R3");
      ign_a = '0; step("R3");
    end

    // R4: fully ignored term is 0 regardless of inputs
    ign_a = '1; ign_b = '1; inv_a = '0; inv_b = '1;
    vin = '0; step("R4");
    vin = '1; step("R4");
    ign_b = 21'h1FFFFE; inv_b = '0; vin = 21'h000001; step("R4");

    // R5: B configuration independent of A
    ign_a = '0; inv_a = '0; vin = 21'h0F0F0F;
    ign_b = 21'h1FFFF0; inv_b = 21'h000000; step("R5");
    inv_b = 21'h00000A; step("R5");
    ign_a = '1; step("R5");

    // R6: OR of terms
    vin = 21'h15A5A5;
    ign_a = 21'h1FFF00; inv_a = ~vin;
    ign_b = 21'h00FFFF; inv_b = ~vin;
    step("R6");
    inv_a = vin; step("R6");
    inv_b = vin; step("R6");
    inv_a = ~vin; inv_b = ~vin; step("R6");

    // R7: enable low forces 0
    cell_en = 1'b0; step("R7");
    cell_en = 1'b1; step("R7");

    // R8: no output change before the edge
    cell_en = 1'b1; ign_a = '0; inv_a = ~vin; ign_b = '1; step("R8");
    inv_a = vin;
    #1;
    chk("R8", cell_q, 1'b1);
    @(posedge clk); @(negedge clk);
    chk("R8", cell_q, 1'b0);

    // Sweep: biased random patterns
    for (int n = 0; n < 3000; n++) begin
      logic [N-1:0] r1, r2, r3;
      vin = N'($urandom);
      r1 = N'($urandom); r2 = N'($urandom); r3 = N'($urandom);
      inv_a = ~vin ^ (r1 & r2 & r3 & N'($urandom));
      inv_b = ~vin ^ (r1 & r2 & N'($urandom) & N'($urandom));
      ign_a = N'($urandom) & N'($urandom);
      ign_b = ((n % 17) == 0) ? '1 : N'($urandom) & N'($urandom);
      cell_en = (($urandom % 8) != 0);
      step("R6");
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule